// File: doc/BRIEF.md
# Isochronous Audio Packet Framer

This block turns a stream of per-frame audio samples into the payloads of outgoing isochronous packets. Each payload opens with a two-quadlet common isochronous packet header and then carries a number of data blocks. Every data block starts with a source packet header timestamp, follows with a 48-bit control field, and then carries the frame's 24-bit samples packed most significant byte first. The block size and the number of blocks per packet depend on a rate mode (1x, 2x or 4x), which is latched when a packet starts.

A controller pulses `pkt_go` once per bus cycle with the cycle time to stamp from. The framer then emits the header, asks for one sample frame per data block over a valid/ready handshake, and streams quadlets with start and end markers and the packet length. A fixed cadence turns every fourth packet into an empty one (header only), so that three full packets and one empty packet make up each cadence round. A single pending MIDI byte may ride in the control field of the first block of a full packet.

Top module: `iso_audio_framer`

## Requirements
- R1: The first header quadlet is {2'b00, SRC_ID[5:0], DBS[7:0], 2'b00 fraction, 3'b000 padding count, 1'b1 source-header flag, 2'b00, DBC[7:0]} with DBS = 0x13 at 1x (rate_mode 0), 0x10 at 2x (rate_mode 1) and 0x09 at 4x (rate_mode 2); SRC_ID defaults to 2.
- R2: The second header quadlet is {2'b10, 6'h02 format, 8'h22 format-dependent field, 16'hFFFF}.
- R3: A full packet holds 8, 16 or 32 data blocks at 1x, 2x or 4x, and out_len, valid with out_sop, gives the quadlet count 2 + blocks x DBS (154, 258, 290), which equals the number of quadlets emitted.
- R4: DBC starts at 0 after reset and, modulo 256, advances after each full packet by that packet's block count; an empty packet carries the DBC of the next full packet.
- R5: Counting packets from reset starting at 0, every packet whose index is 3 modulo 4 is empty: two header quadlets, out_len = 2, out_eop on the second quadlet, and no sample frame consumed.
- R6: Each block's first quadlet is {7'b0, count[12:0], offset[11:0]}; block k of a packet stamps the base cycle_time plus k x 512, 256 or 128 (1x, 2x, 4x) offset ticks, with the offset wrapping at 3072 into the count and the count wrapping at 8000.
- R7: At 1x a block carries, after its timestamp, the 48-bit control field and then smp_frame slots 0..21 (slot i at bits [24i+23:24i]: 0-1 headphone, 2-9 analog, 10-11 AES/EBU, 12-13 coaxial digital, 14-21 optical) packed MSB first; at 2x slots 0..17 only.
- R8: At 4x a block carries the control field, slots 2..9, then 16 zero bits.
- R9: If midi_valid is high when a full packet starts, the control field of its first block is {8'h01, 8'h00, midi_byte, 24'h0} and midi_ack pulses for one cycle just before out_sop; every other control field is zero, and an empty packet takes no MIDI byte.
- R10: smp_ready is high only while a block waits for its frame; while smp_valid is low there, no quadlet is emitted and none is lost.
- R11: out_sop marks the first and out_eop the last quadlet of a packet; pkt_go and rate_mode are ignored while a packet is in progress.
- R12: After reset out_valid, smp_ready and midi_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_mode | input | 2 | 0 = 1x, 1 = 2x, 2 = 4x; sampled at packet start |
| pkt_go | input | 1 | Start one packet (taken when idle) |
| cycle_time | input | 25 | Base stamp {count[12:0], offset[11:0]} |
| smp_valid | input | 1 | Sample frame present |
| smp_ready | output | 1 | Framer takes a frame this cycle |
| smp_frame | input | 528 | 22 slots of 24-bit samples |
| midi_valid | input | 1 | A MIDI byte is pending |
| midi_byte | input | 8 | Pending MIDI byte |
| midi_ack | output | 1 | Pending MIDI byte was taken |
| out_valid | output | 1 | Quadlet valid |
| out_data | output | 32 | Payload quadlet |
| out_sop | output | 1 | First quadlet of packet |
| out_eop | output | 1 | Last quadlet of packet |
| out_len | output | 10 | Packet length in quadlets, valid with out_sop |

## Verification
Two functions collide in one cycle when a MIDI byte is pending at the moment the cadence selects an empty packet, and when a block boundary that carries the timestamp into a new count meets a missing sample frame. The bench provokes the first by holding midi_valid across the fourth packet of a round and expects no acknowledge and an all-zero control field, and the second by starting near count 7999, offset 3000 with a stalling sample source, comparing every emitted quadlet against arithmetic stamps and packing computed in the bench. A third overlap, a new start request and rate change arriving mid-packet, is judged by an unchanged packet and silence afterwards.

// File: rtl/iaf_pkg.sv
package iaf_pkg;
    localparam int SMP_W   = 24;
    localparam int NCH     = 22;
    localparam int CTRL_W  = 48;
    localparam int QW      = 32;
    localparam int FRAME_W = NCH * SMP_W;
    localparam int BODY_W  = CTRL_W + FRAME_W;
    localparam int LEN_W   = 10;
    localparam int DBC_W   = 8;
    localparam int OFF_W   = 12;
    localparam int CYC_W   = 13;
    localparam int OFF_MOD = 3072;
    localparam int CYC_MOD = 8000;

    localparam logic [5:0]  CIP_FMT = 6'h02;
    localparam logic [7:0]  CIP_FDF = 8'h22;
    localparam logic [15:0] CIP_SYT = 16'hFFFF;

    localparam logic [1:0] RATE_1X = 2'd0;
    localparam logic [1:0] RATE_2X = 2'd1;
    localparam logic [1:0] RATE_4X = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR0, ST_HDR1, ST_WAIT, ST_BODY
    } fr_state_e;

    typedef struct packed {
        logic [7:0]       dbs;
        logic [5:0]       nblk;
        logic [OFF_W-1:0] inc;
    } rate_cfg_t;

    function automatic rate_cfg_t cfg_of(input logic [1:0] m);
        rate_cfg_t c;
        case (m)
            RATE_2X: c = '{dbs: 8'h10, nblk: 6'd16, inc: 12'd256};
            RATE_4X: c = '{dbs: 8'h09, nblk: 6'd32, inc: 12'd128};
            default: c = '{dbs: 8'h13, nblk: 6'd8,  inc: 12'd512};
        endcase
        return c;
    endfunction

    function automatic logic [BODY_W-1:0] pack_body(
        input logic [1:0]         m,
        input logic [CTRL_W-1:0]  ctrl,
        input logic [FRAME_W-1:0] fr
    );
        logic [BODY_W-1:0] b;
        b = '0;
        b[BODY_W-1 -: CTRL_W] = ctrl;
        for (int i = 0; i < NCH; i++) begin
            if (m == RATE_4X) begin
                if (i >= 2 && i < 10)
                    b[BODY_W-CTRL_W-SMP_W*(i-1) +: SMP_W] = fr[SMP_W*i +: SMP_W];
            end else if (m == RATE_2X) begin
                if (i < 18)
                    b[BODY_W-CTRL_W-SMP_W*(i+1) +: SMP_W] = fr[SMP_W*i +: SMP_W];
            end else begin
                b[BODY_W-CTRL_W-SMP_W*(i+1) +: SMP_W] = fr[SMP_W*i +: SMP_W];
            end
        end
        return b;
    endfunction
endpackage

// File: rtl/iaf_stamp.sv
module iaf_stamp
    import iaf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [CYC_W+OFF_W-1:0] base,
    input  logic                   step,
    input  logic [OFF_W-1:0]       inc,
    output logic [QW-1:0]          sph
);
    logic [CYC_W-1:0] cyc_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W:0]   sum;

    assign sum = {1'b0, off_q} + {1'b0, inc};

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            off_q <= '0;
        end else if (load) begin
            cyc_q <= base[CYC_W+OFF_W-1:OFF_W];
            off_q <= base[OFF_W-1:0];
        end else if (step) begin
            if (sum >= (OFF_W+1)'(OFF_MOD)) begin
                off_q <= OFF_W'(sum - (OFF_W+1)'(OFF_MOD));
                cyc_q <= (cyc_q == CYC_W'(CYC_MOD-1)) ? '0 : cyc_q + 1'b1;
            end else begin
                off_q <= sum[OFF_W-1:0];
            end
        end
    end

    assign sph = {{(QW-CYC_W-OFF_W){1'b0}}, cyc_q, off_q};
endmodule

// File: rtl/iaf_cadence.sv
module iaf_cadence
    import iaf_pkg::*;
#(
    parameter int EMPTY_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             full_done,
    input  logic [5:0]       nblk,
    output logic             is_empty,
    output logic [DBC_W-1:0] dbc
);
    localparam int PC_W = (EMPTY_PERIOD > 2) ? $clog2(EMPTY_PERIOD) : 1;

    logic [PC_W-1:0] pcnt;

    assign is_empty = (pcnt == PC_W'(EMPTY_PERIOD-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            dbc  <= '0;
        end else begin
            if (start)
                pcnt <= is_empty ? '0 : pcnt + 1'b1;
            if (full_done)
                dbc <= dbc + DBC_W'(nblk);
        end
    end
endmodule

// File: rtl/iaf_shifter.sv
module iaf_shifter
    import iaf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BODY_W-1:0] body_in,
    input  logic              shift,
    output logic [QW-1:0]     head
);
    logic [BODY_W-1:0] body_q;

    always_ff @(posedge clk) begin
        if (rst)
            body_q <= '0;
        else if (load)
            body_q <= body_in;
        else if (shift)
            body_q <= body_q << QW;
    end

    assign head = body_q[BODY_W-1 -: QW];
endmodule

// File: rtl/iso_audio_framer.sv
module iso_audio_framer
    import iaf_pkg::*;
#(
    parameter logic [5:0] SRC_ID       = 6'd2,
    parameter int         EMPTY_PERIOD = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         rate_mode,
    input  logic               pkt_go,
    input  logic [24:0]        cycle_time,
    input  logic               smp_valid,
    output logic               smp_ready,
    input  logic [FRAME_W-1:0] smp_frame,
    input  logic               midi_valid,
    input  logic [7:0]         midi_byte,
    output logic               midi_ack,
    output logic               out_valid,
    output logic [QW-1:0]      out_data,
    output logic               out_sop,
    output logic               out_eop,
    output logic [LEN_W-1:0]   out_len
);
    fr_state_e        st;
    logic [1:0]       mode_q;
    logic             empty_q;
    logic             midi_q;
    logic [7:0]       midi_b_q;
    logic [5:0]       blk_idx;
    logic [4:0]       qidx;
    rate_cfg_t        cfg;
    logic             cad_empty;
    logic [DBC_W-1:0] dbc;
    logic [QW-1:0]    sph;
    logic [QW-1:0]    head;
    logic [CTRL_W-1:0] ctrl;
    logic             pkt_accept, blk_accept, last_q, last_blk;
    logic             stamp_step, full_done;
    logic [LEN_W-1:0] full_len;

    assign cfg        = cfg_of(mode_q);
    assign pkt_accept = (st == ST_IDLE) && pkt_go;
    assign blk_accept = (st == ST_WAIT) && smp_valid;
    assign last_q     = (st == ST_BODY) && (qidx == 5'(cfg.dbs - 8'd2));
    assign last_blk   = (blk_idx == cfg.nblk - 6'd1);
    assign stamp_step = last_q && !last_blk;
    assign full_done  = last_q && last_blk;
    assign smp_ready  = (st == ST_WAIT);
    assign full_len   = LEN_W'(2) + LEN_W'(cfg.nblk) * LEN_W'(cfg.dbs);
    assign ctrl       = (midi_q && blk_idx == '0) ? {8'h01, 8'h00, midi_b_q, 24'h0}
                                                  : '0;

    iaf_stamp u_stamp (
        .clk(clk), .rst(rst), .load(pkt_accept), .base(cycle_time),
        .step(stamp_step), .inc(cfg.inc), .sph(sph)
    );

    iaf_cadence #(.EMPTY_PERIOD(EMPTY_PERIOD)) u_cad (
        .clk(clk), .rst(rst), .start(pkt_accept), .full_done(full_done),
        .nblk(cfg.nblk), .is_empty(cad_empty), .dbc(dbc)
    );

    iaf_shifter u_shift (
        .clk(clk), .rst(rst), .load(blk_accept),
        .body_in(pack_body(mode_q, ctrl, smp_frame)),
        .shift(st == ST_BODY), .head(head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            mode_q    <= RATE_1X;
            empty_q   <= 1'b0;
            midi_q    <= 1'b0;
            midi_b_q  <= '0;
            blk_idx   <= '0;
            qidx      <= '0;
            midi_ack  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_len   <= '0;
        end else begin
            midi_ack  <= 1'b0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_len   <= '0;
            case (st)
                ST_IDLE: if (pkt_go) begin
                    mode_q   <= rate_mode;
                    empty_q  <= cad_empty;
                    midi_q   <= midi_valid && !cad_empty;
                    midi_b_q <= midi_byte;
                    midi_ack <= midi_valid && !cad_empty;
                    st       <= ST_HDR0;
                end
                ST_HDR0: begin
                    out_valid <= 1'b1;
                    out_sop   <= 1'b1;
                    out_len   <= empty_q ? LEN_W'(2) : full_len;
                    out_data  <= {2'b00, SRC_ID, cfg.dbs, 2'b00, 3'b000,
                                  1'b1, 2'b00, dbc};
                    st        <= ST_HDR1;
                end
                ST_HDR1: begin
                    out_valid <= 1'b1;
                    out_eop   <= empty_q;
                    out_data  <= {2'b10, CIP_FMT, CIP_FDF, CIP_SYT};
                    blk_idx   <= '0;
                    st        <= empty_q ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: if (smp_valid) begin
                    out_valid <= 1'b1;
                    out_data  <= sph;
                    qidx      <= '0;
                    st        <= ST_BODY;
                end
                ST_BODY: begin
                    out_valid <= 1'b1;
                    out_data  <= head;
                    if (last_q) begin
                        if (last_blk) begin
                            out_eop <= 1'b1;
                            st      <= ST_IDLE;
                        end else begin
                            blk_idx <= blk_idx + 1'b1;
                            st      <= ST_WAIT;
                        end
                    end else begin
                        qidx <= qidx + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iaf_checker.sv
module iaf_checker (
    input logic        clk,
    input logic        rst,
    input logic        smp_valid,
    input logic        smp_ready,
    input logic        midi_ack,
    input logic        out_valid,
    input logic [31:0] out_data,
    input logic        out_sop,
    input logic        out_eop,
    input logic [9:0]  out_len
);
    AST_SOP_VALID: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid && !out_eop); // R11

    AST_EOP_VALID: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> out_valid); // R11

    AST_HDR0_FIELDS: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_data[10] && out_data[15:11] == 5'd0 && out_data[31:30] == 2'b00
                    && (out_data[23:16] == 8'h13 || out_data[23:16] == 8'h10
                        || out_data[23:16] == 8'h09)); // R1

    AST_HDR1_NEXT: assert property (@(posedge clk) disable iff (rst)
        out_sop |=> out_valid && out_data == 32'h8222FFFF); // R2

    AST_LEN_SET: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> (out_len == 10'd2 || out_len == 10'd154
                     || out_len == 10'd258 || out_len == 10'd290)); // R3

    AST_EMPTY_SHAPE: assert property (@(posedge clk) disable iff (rst)
        out_sop && out_len == 10'd2 |=> out_eop); // R5

    AST_SPH_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        smp_ready && smp_valid |=> out_valid && out_data[31:25] == 7'd0
                                   && out_data[11:0] < 12'd3072); // R6

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        smp_ready && !smp_valid |=> !out_valid); // R10

    AST_MIDI_LEAD: assert property (@(posedge clk) disable iff (rst)
        midi_ack |=> out_sop && !midi_ack); // R9
endmodule

bind iso_audio_framer iaf_checker u_iaf_checker (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .midi_ack(midi_ack), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_len(out_len)
);

// File: tb/iso_audio_framer_bench.sv
`timescale 1ns/1ps
module iso_audio_framer_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   rate_mode = 2'd0;
    logic         pkt_go = 1'b0;
    logic [24:0]  cycle_time = '0;
    logic         smp_valid = 1'b0;
    logic         smp_ready;
    logic [527:0] smp_frame = '0;
    logic         midi_valid = 1'b0;
    logic [7:0]   midi_byte = '0;
    logic         midi_ack;
    logic         out_valid;
    logic [31:0]  out_data;
    logic         out_sop;
    logic         out_eop;
    logic [9:0]   out_len;

    int n_run = 0;
    int n_fail = 0;
    int pkt_no = 0;
    int frame_next = 0;
    logic [7:0] dbc_m = '0;

    always #2 clk = ~clk;

    iso_audio_framer u_iso_audio_framer (
        .clk(clk), .rst(rst), .rate_mode(rate_mode), .pkt_go(pkt_go),
        .cycle_time(cycle_time), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_frame(smp_frame), .midi_valid(midi_valid), .midi_byte(midi_byte),
        .midi_ack(midi_ack), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_len(out_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] samp(input int f, input int c);
        return {8'(f), 8'(c), 8'(f * 3 + c) ^ 8'h5A};
    endfunction

    // sample source with optional two-cycle stall per block
    logic acc_q = 1'b0, rdy_q = 1'b0, stall_q = 1'b0;
    bit   stall_en = 1'b0;
    int   frame_ctr = 0;
    int   hold = 0;

    always @(posedge clk) begin
        acc_q   <= smp_valid && smp_ready;
        rdy_q   <= smp_ready;
        stall_q <= smp_ready && !smp_valid;
    end

    always @(negedge clk) begin
        if (acc_q) begin
            frame_ctr++;
            hold = 0;
        end else if (rdy_q) begin
            hold++;
        end
        for (int c = 0; c < 22; c++) smp_frame[24*c +: 24] = samp(frame_ctr, c);
        smp_valid = !stall_en || (hold >= 2);
        if (stall_q) chk(!out_valid, "R10", "quadlet during stall", 64'(out_valid), 64'd0);
    end

    function automatic logic [575:0] exp_body(input int mode, input int f,
                                              input bit mid, input logic [7:0] mb);
        logic [575:0] b;
        int pos;
        b = '0;
        if (mid) b[575:528] = {8'h01, 8'h00, mb, 24'h0};
        pos = 528;
        if (mode == 2) begin
            for (int c = 2; c < 10; c++) begin b[pos-24 +: 24] = samp(f, c); pos -= 24; end
        end else begin
            for (int c = 0; c < ((mode == 1) ? 18 : 22); c++) begin
                b[pos-24 +: 24] = samp(f, c); pos -= 24;
            end
        end
        return b;
    endfunction

    task automatic run_pkt(input int mode, input bit midi_en, input logic [7:0] mb,
                           input int cyc, input int off, input bit poke, input bit stall);
        bit empty;
        int dbs, nblk, inc, elen, idx, waitc, k, j, tot, quiet;
        logic [31:0] e;
        logic [575:0] body;
        string req;
        empty = (pkt_no % 4) == 3;
        dbs  = (mode == 2) ? 9 : ((mode == 1) ? 16 : 19);
        nblk = (mode == 2) ? 32 : ((mode == 1) ? 16 : 8);
        inc  = (mode == 2) ? 128 : ((mode == 1) ? 256 : 512);
        elen = empty ? 2 : 2 + nblk * dbs;
        stall_en = stall;
        @(negedge clk);
        rate_mode = 2'(mode); cycle_time = {13'(cyc), 12'(off)};
        midi_valid = midi_en; midi_byte = mb; pkt_go = 1'b1;
        @(negedge clk);
        pkt_go = 1'b0;
        chk(midi_ack == (midi_en && !empty), "R9", "midi_ack", 64'(midi_ack),
            64'(midi_en && !empty));
        midi_valid = 1'b0;
        idx = 0; waitc = 0;
        while (idx < elen && waitc < 4000) begin
            if (out_valid) begin
                if (idx == 0) begin
                    chk(out_sop, "R11", "sop", 64'(out_sop), 64'd1);
                    chk(out_len == 10'(elen), empty ? "R5" : "R3", "len", 64'(out_len), 64'(elen));
                    e = {2'b00, 6'd2, 8'(dbs), 2'b00, 3'b000, 1'b1, 2'b00, 8'h00};
                    chk(out_data[31:8] == e[31:8], "R1", "hdr0", 64'(out_data), 64'(e));
                    chk(out_data[7:0] == dbc_m, "R4", "dbc", 64'(out_data[7:0]), 64'(dbc_m));
                end else if (idx == 1) begin
                    chk(out_data == 32'h8222FFFF, "R2", "hdr1", 64'(out_data), 64'h8222FFFF);
                end else begin
                    k = (idx - 2) / dbs; j = (idx - 2) % dbs;
                    if (j == 0) begin
                        tot = cyc * 3072 + off + k * inc;
                        e = {7'd0, 13'((tot / 3072) % 8000), 12'(tot % 3072)};
                        req = "R6";
                    end else begin
                        body = exp_body(mode, frame_next + k, midi_en && k == 0, mb);
                        e = body[575 - 32*(j-1) -: 32];
                        req = (j <= 2) ? "R9" : ((mode == 2) ? "R8" : "R7");
                    end
                    chk(out_data == e, req, "quadlet", 64'(out_data), 64'(e));
                end
                chk(out_eop == (idx == elen - 1), empty ? "R5" : "R11", "eop",
                    64'(out_eop), 64'(idx == elen - 1));
                idx++;
            end
            pkt_go = poke && idx >= 5 && idx < 8;
            if (poke && idx >= 5) rate_mode = 2'(mode == 0 ? 2 : 0);
            waitc++;
            @(negedge clk);
        end
        pkt_go = 1'b0;
        chk(idx == elen, "R3", "quadlet count", 64'(idx), 64'(elen));
        if (poke) begin
            quiet = 0;
            repeat (20) begin if (out_valid) quiet++; @(negedge clk); end
            chk(quiet == 0, "R11", "output after ignored start", 64'(quiet), 64'd0);
        end
        if (!empty) begin
            dbc_m = dbc_m + 8'(nblk);
            frame_next += nblk;
        end
        chk(frame_ctr == frame_next, empty ? "R5" : "R10", "frames taken",
            64'(frame_ctr), 64'(frame_next));
        pkt_no++;
        stall_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!out_valid && !smp_ready && !midi_ack, "R12", "reset outputs",
            64'({out_valid, smp_ready, midi_ack}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !smp_ready, "R12", "idle after reset",
            64'({out_valid, smp_ready}), 64'd0);
        // 1x round: carry across offset and count wrap, MIDI, stalls, MIDI on empty slot
        run_pkt(0, 1, 8'h90, 7999, 3000, 0, 0);
        run_pkt(0, 0, 8'h00, 100, 0, 0, 1);
        run_pkt(0, 1, 8'h3C, 4000, 2600, 1, 0);
        run_pkt(0, 1, 8'h7F, 5, 5, 0, 0);
        // 2x round
        run_pkt(1, 1, 8'h7F, 7998, 3071, 0, 1);
        run_pkt(1, 0, 8'h00, 0, 0, 1, 0);
        run_pkt(1, 0, 8'h00, 1234, 2047, 0, 0);
        run_pkt(1, 0, 8'h00, 0, 0, 0, 0);
        // 4x rounds, DBC wraps past 255
        run_pkt(2, 1, 8'hA5, 7999, 3050, 0, 0);
        run_pkt(2, 0, 8'h00, 10, 10, 0, 1);
        run_pkt(2, 1, 8'h01, 200, 3000, 0, 0);
        run_pkt(2, 0, 8'h00, 0, 0, 0, 0);
        run_pkt(2, 0, 8'h00, 7000, 1000, 1, 0);
        run_pkt(2, 1, 8'hFE, 1, 1, 0, 0);
        run_pkt(2, 0, 8'h00, 2, 2, 0, 1);
        run_pkt(2, 0, 8'h00, 3, 3, 0, 0);
        run_pkt(0, 0, 8'h00, 50, 50, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule